// File: doc/BRIEF.md
# Register Rename Status Table

This block tracks, for every architectural floating-point register, whether a newer value is still being computed and, if so, which reservation station will produce it. The issue stage writes a rename each time it dispatches an instruction: the destination register is bound to the tag of the station that accepted it. On the same cycle, the issue stage can look up two source registers. Each lookup returns either a ready value or the tag of the station that is still producing the value.

Completed functional units raise a request together with the sequence number their instruction received at issue. A combinational arbiter grants the single result bus to the oldest requester. The granted unit's index serves as the broadcast tag. Each table entry that holds that tag commits the broadcast data to the internal register bank through the register-file write port and drops back to empty. An entry renamed since then keeps its newer tag, and the stale result does not reach the register bank.

Each table entry is a two-state machine. The states are EMPTY (the value lives in the register bank) and PENDING (a producer tag is held). The transitions are:
- EMPTY to PENDING on a rename.
- PENDING to PENDING, with a new tag, on a rename.
- PENDING to EMPTY on a matching broadcast with no rename in the same cycle.
- Any other case keeps the state.

Top module: `rename_status_unit`

## Requirements
- R1: After reset every entry is EMPTY, and every lookup returns ready=1 with value 0.
- R2: A lookup of an EMPTY register returns ready=1 and the value last committed to that register.
- R3: A lookup of a PENDING register with no matching broadcast in that cycle returns ready=0 and the held producer tag.
- R4: A rename (iss_valid=1) sets the destination entry to PENDING with iss_tag from the next cycle. This also applies when the entry was already PENDING with another tag.
- R5: When the bus tag equals a PENDING entry's tag, rf_we=1, rf_waddr is that register and rf_wdata is the bus data in the same cycle. From the next cycle the entry is EMPTY and reads back that data.
- R6: A broadcast whose tag matches no PENDING entry raises no rf_we and leaves every entry and register value unchanged.
- R7: The bus carries exactly one requester. The candidates are scanned from unit 0 upward, and a later requester replaces the current choice only when (its seq minus the chosen seq) mod 2^SEQ_W has its top bit set. The winner gets a one-hot done_grant bit, bus_tag equals its unit index, and bus_data equals its data slice.
- R8: With no request raised, bus_valid=0, done_grant=0 and rf_we=0.
- R9: A rename and a matching broadcast to the same register in one cycle still commit the data (rf_we=1). The entry then holds the new tag and stays PENDING.
- R10: A lookup of a PENDING register in the cycle its matching broadcast appears returns ready=1 with the bus data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Rename request from issue |
| iss_reg | input | REG_W | Destination register being renamed |
| iss_tag | input | TAG_W | Station tag that will produce the destination |
| lka_reg | input | REG_W | Source lookup A register |
| lka_ready | output | 1 | Lookup A value is available |
| lka_value | output | DATA_W | Lookup A value (0 when not ready) |
| lka_tag | output | TAG_W | Lookup A producer tag (0 when entry empty) |
| lkb_reg | input | REG_W | Source lookup B register |
| lkb_ready | output | 1 | Lookup B value is available |
| lkb_value | output | DATA_W | Lookup B value (0 when not ready) |
| lkb_tag | output | TAG_W | Lookup B producer tag (0 when entry empty) |
| done_req | input | NUM_UNITS | Per-unit result-ready request |
| done_seq | input | NUM_UNITS*SEQ_W | Per-unit issue sequence numbers, unit i at bits i*SEQ_W |
| done_data | input | NUM_UNITS*DATA_W | Per-unit results, unit i at bits i*DATA_W |
| done_grant | output | NUM_UNITS | One-hot bus grant |
| bus_valid | output | 1 | Result bus active |
| bus_tag | output | TAG_W | Tag (unit index) on the bus |
| bus_data | output | DATA_W | Data on the bus |
| rf_we | output | 1 | Register bank write enable |
| rf_waddr | output | REG_W | Register bank write address |
| rf_wdata | output | DATA_W | Register bank write data |

## Verification
The grant, bus, lookup and register-write outputs are combinational, so they are due in the same cycle as the stimulus. The bench drives just after a falling edge and samples 1 ns later, before the next rising edge. Table and register-bank state changes become visible only after the next rising edge. These effects are therefore checked through lookups in the following cycle, while no rename or request is active, so the sampled state cannot move under the check. The arbitration sweep holds all entries empty, which makes the intervening edges harmless.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
package rsu_pkg;
    typedef enum logic {
        ENT_EMPTY   = 1'b0,
        ENT_PENDING = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rsu_bus_arbiter.sv
`timescale 1ns/1ps
module rsu_bus_arbiter #(
    parameter int NUM_UNITS = 4,
    parameter int SEQ_W     = 4,
    localparam int TAG_W    = $clog2(NUM_UNITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_UNITS-1:0]       req,
    input  logic [NUM_UNITS*SEQ_W-1:0] seq,
    output logic [NUM_UNITS-1:0]       grant,
    output logic                       win_valid,
    output logic [TAG_W-1:0]           win_idx
);
    function automatic logic is_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_seq  = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (req[i]) begin
                if (!win_valid || is_older(seq[i*SEQ_W +: SEQ_W], best_seq)) begin
                    win_valid = 1'b1;
                    win_idx   = TAG_W'(i);
                    best_seq  = seq[i*SEQ_W +: SEQ_W];
                end
            end
        end
    end

    always_comb begin
        grant = '0;
        if (win_valid) grant[win_idx] = 1'b1;
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
    // R7
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == '0);
    // R7
    req_served_chk: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> ($countones(grant) == 1));
endmodule

// File: rtl/rsu_status_table.sv
`timescale 1ns/1ps
module rsu_status_table
    import rsu_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ren_valid,
    input  logic [REG_W-1:0]              ren_reg,
    input  logic [TAG_W-1:0]              ren_tag,
    input  logic                          bc_valid,
    input  logic [TAG_W-1:0]              bc_tag,
    output logic [NUM_REGS-1:0]           pend,
    output logic [TAG_W-1:0]              tags [NUM_REGS],
    output logic [NUM_REGS-1:0]           hit
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        ent_state_e       st_q, st_d;
        logic [TAG_W-1:0] tag_q, tag_d;
        logic             ren_here;

        assign ren_here = ren_valid && (ren_reg == REG_W'(g));
        assign hit[g]   = (st_q == ENT_PENDING) && bc_valid && (tag_q == bc_tag);
        assign pend[g]  = (st_q == ENT_PENDING);
        assign tags[g]  = tag_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= ENT_EMPTY;
                tag_q <= '0;
            end else begin
                st_q  <= st_d;
                tag_q <= tag_d;
            end
        end

        always_comb begin
            st_d  = st_q;
            tag_d = tag_q;
            unique case (st_q)
                ENT_EMPTY: begin
                    if (ren_here) begin
                        st_d  = ENT_PENDING;
                        tag_d = ren_tag;
                    end
                end
                ENT_PENDING: begin
                    if (ren_here) begin
                        tag_d = ren_tag;
                    end else if (hit[g]) begin
                        st_d = ENT_EMPTY;
                    end
                end
                default: st_d = ENT_EMPTY;
            endcase
        end

        // R4
        ren_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ren_here |=> (st_q == ENT_PENDING && tag_q == $past(ren_tag)));
        // R6
        stale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ENT_PENDING && !ren_here && !(bc_valid && bc_tag == tag_q))
            |=> (st_q == ENT_PENDING && $stable(tag_q)));
        // R5
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ENT_PENDING && bc_valid && bc_tag == tag_q && !ren_here)
            |=> (st_q == ENT_EMPTY));
    end
endmodule

// File: rtl/rsu_reg_bank.sv
`timescale 1ns/1ps
module rsu_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [REG_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rename_status_unit.sv
`timescale 1ns/1ps
module rename_status_unit #(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_UNITS = 4,
    parameter int SEQ_W     = 4,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int TAG_W    = $clog2(NUM_UNITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic [REG_W-1:0]            iss_reg,
    input  logic [TAG_W-1:0]            iss_tag,
    input  logic [REG_W-1:0]            lka_reg,
    output logic                        lka_ready,
    output logic [DATA_W-1:0]           lka_value,
    output logic [TAG_W-1:0]            lka_tag,
    input  logic [REG_W-1:0]            lkb_reg,
    output logic                        lkb_ready,
    output logic [DATA_W-1:0]           lkb_value,
    output logic [TAG_W-1:0]            lkb_tag,
    input  logic [NUM_UNITS-1:0]        done_req,
    input  logic [NUM_UNITS*SEQ_W-1:0]  done_seq,
    input  logic [NUM_UNITS*DATA_W-1:0] done_data,
    output logic [NUM_UNITS-1:0]        done_grant,
    output logic                        bus_valid,
    output logic [TAG_W-1:0]            bus_tag,
    output logic [DATA_W-1:0]           bus_data,
    output logic                        rf_we,
    output logic [REG_W-1:0]            rf_waddr,
    output logic [DATA_W-1:0]           rf_wdata
);
    localparam int NUM_LOOK = 2;

    logic [NUM_REGS-1:0] pend;
    logic [NUM_REGS-1:0] hit;
    logic [TAG_W-1:0]    tags [NUM_REGS];

    rsu_bus_arbiter #(.NUM_UNITS(NUM_UNITS), .SEQ_W(SEQ_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (done_req),
        .seq       (done_seq),
        .grant     (done_grant),
        .win_valid (bus_valid),
        .win_idx   (bus_tag)
    );

    assign bus_data = done_data[bus_tag*DATA_W +: DATA_W];

    rsu_status_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ren_valid (iss_valid),
        .ren_reg   (iss_reg),
        .ren_tag   (iss_tag),
        .bc_valid  (bus_valid),
        .bc_tag    (bus_tag),
        .pend      (pend),
        .tags      (tags),
        .hit       (hit)
    );

    always_comb begin
        rf_waddr = '0;
        for (int r = NUM_REGS - 1; r >= 0; r--) begin
            if (hit[r]) rf_waddr = REG_W'(r);
        end
    end
    assign rf_we    = |hit;
    assign rf_wdata = bus_data;

    logic [REG_W-1:0]  lk_reg   [NUM_LOOK];
    logic [DATA_W-1:0] rf_rd    [NUM_LOOK];
    logic              lk_ready [NUM_LOOK];
    logic [DATA_W-1:0] lk_val   [NUM_LOOK];
    logic [TAG_W-1:0]  lk_tag   [NUM_LOOK];

    assign lk_reg[0] = lka_reg;
    assign lk_reg[1] = lkb_reg;

    rsu_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (lk_reg[0]),
        .rdata_a (rf_rd[0]),
        .raddr_b (lk_reg[1]),
        .rdata_b (rf_rd[1])
    );

    for (genvar p = 0; p < NUM_LOOK; p++) begin : g_look
        always_comb begin
            if (!pend[lk_reg[p]]) begin
                lk_ready[p] = 1'b1;
                lk_val[p]   = rf_rd[p];
                lk_tag[p]   = '0;
            end else if (hit[lk_reg[p]]) begin
                lk_ready[p] = 1'b1;
                lk_val[p]   = bus_data;
                lk_tag[p]   = tags[lk_reg[p]];
            end else begin
                lk_ready[p] = 1'b0;
                lk_val[p]   = '0;
                lk_tag[p]   = tags[lk_reg[p]];
            end
        end
    end

    assign lka_ready = lk_ready[0];
    assign lka_value = lk_val[0];
    assign lka_tag   = lk_tag[0];
    assign lkb_ready = lk_ready[1];
    assign lkb_value = lk_val[1];
    assign lkb_tag   = lk_tag[1];

    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|done_req) |-> (!bus_valid && !rf_we));
    // R5
    write_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> bus_valid);
endmodule

// File: tb/rename_status_unit_bench.sv
`timescale 1ns/1ps
module rename_status_unit_bench;
    localparam int NR = 8, DW = 16, NU = 4, SW = 4;
    localparam int RW = 3, TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          iss_valid = 1'b0;
    logic [RW-1:0] iss_reg = '0;
    logic [TW-1:0] iss_tag = '0;
    logic [RW-1:0] lka_reg = '0, lkb_reg = '0;
    logic          lka_ready, lkb_ready;
    logic [DW-1:0] lka_value, lkb_value;
    logic [TW-1:0] lka_tag, lkb_tag;
    logic [NU-1:0]    done_req = '0;
    logic [NU*SW-1:0] done_seq = '0;
    logic [NU*DW-1:0] done_data = '0;
    logic [NU-1:0] done_grant;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_data;
    logic          rf_we;
    logic [RW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;

    rename_status_unit u_rename_status_unit (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_tag(iss_tag),
        .lka_reg(lka_reg), .lka_ready(lka_ready), .lka_value(lka_value), .lka_tag(lka_tag),
        .lkb_reg(lkb_reg), .lkb_ready(lkb_ready), .lkb_value(lkb_value), .lkb_tag(lkb_tag),
        .done_req(done_req), .done_seq(done_seq), .done_data(done_data),
        .done_grant(done_grant), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    int tests = 0;
    int fails = 0;
    bit m_pend [NR];
    int m_tag  [NR];
    int m_val  [NR];

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_unit(input int u, input bit r, input int s, input int d);
        done_req[u]            = r;
        done_seq[u*SW +: SW]   = SW'(s);
        done_data[u*DW +: DW]  = DW'(d);
    endtask

    function automatic int exp_winner();
        int best = -1;
        for (int i = 0; i < NU; i++) begin
            if (done_req[i]) begin
                if (best < 0) best = i;
                else if (((int'(done_seq[i*SW +: SW]) - int'(done_seq[best*SW +: SW])) & 8) != 0) best = i;
            end
        end
        return best;
    endfunction

    task automatic cycle();
        int w;
        w = exp_winner();
        if (w >= 0) begin
            for (int r = 0; r < NR; r++) begin
                if (m_pend[r] && m_tag[r] == w) begin
                    m_pend[r] = 1'b0;
                    m_val[r]  = int'(done_data[w*DW +: DW]);
                end
            end
        end
        if (iss_valid) begin
            m_pend[iss_reg] = 1'b1;
            m_tag[iss_reg]  = int'(iss_tag);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string empty_req);
        for (int r = 0; r < NR; r++) begin
            lka_reg = RW'(r);
            lkb_reg = RW'(NR - 1 - r);
            #1;
            if (m_pend[r]) begin
                chk("R3 ready A", int'(lka_ready), 0);
                chk("R3 tag A", int'(lka_tag), m_tag[r]);
            end else begin
                chk({empty_req, " ready A"}, int'(lka_ready), 1);
                chk({empty_req, " value A"}, int'(lka_value), m_val[r]);
            end
            if (m_pend[NR-1-r]) begin
                chk("R3 ready B", int'(lkb_ready), 0);
                chk("R3 tag B", int'(lkb_tag), m_tag[NR-1-r]);
            end else begin
                chk({empty_req, " ready B"}, int'(lkb_ready), 1);
                chk({empty_req, " value B"}, int'(lkb_value), m_val[NR-1-r]);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_pend[r] = 1'b0; m_tag[r] = 0; m_val[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // Renames of three registers (R4), then lookups (R2, R3)
        iss_valid = 1'b1;
        iss_reg = 3'd2; iss_tag = 2'd0; cycle();
        iss_reg = 3'd5; iss_tag = 2'd1; cycle();
        iss_reg = 3'd7; iss_tag = 2'd2; cycle();
        iss_valid = 1'b0;
        check_all("R2");

        // R4: retag a pending register
        iss_valid = 1'b1; iss_reg = 3'd5; iss_tag = 2'd3; cycle();
        iss_valid = 1'b0;
        lka_reg = 3'd5; #1;
        chk("R4 ready", int'(lka_ready), 0);
        chk("R4 tag", int'(lka_tag), 3);

        // R6: stale broadcast from unit 1
        set_unit(1, 1'b1, 0, 'h1111); #1;
        chk("R6 rf_we", int'(rf_we), 0);
        chk("R7 bus_tag", int'(bus_tag), 1);
        cycle();
        set_unit(1, 1'b0, 0, 0); #1;
        chk("R6 still pending", int'(lka_ready), 0);
        chk("R6 tag kept", int'(lka_tag), 3);
        @(negedge clk);

        // R10 and R5: matching broadcast for register 2
        set_unit(0, 1'b1, 1, 'hA0A0);
        lka_reg = 3'd2; #1;
        chk("R10 ready", int'(lka_ready), 1);
        chk("R10 value", int'(lka_value), 'hA0A0);
        chk("R5 rf_we", int'(rf_we), 1);
        chk("R5 rf_waddr", int'(rf_waddr), 2);
        chk("R5 rf_wdata", int'(rf_wdata), 'hA0A0);
        cycle();
        set_unit(0, 1'b0, 0, 0); #1;
        chk("R5 ready after", int'(lka_ready), 1);
        chk("R5 value after", int'(lka_value), 'hA0A0);
        @(negedge clk);

        // R7: two requesters, unit 3 (seq 3) older than unit 2 (seq 5)
        set_unit(2, 1'b1, 5, 'h2222);
        set_unit(3, 1'b1, 3, 'h3333); #1;
        chk("R7 grant pair", int'(done_grant), 'b1000);
        chk("R7 bus_data pair", int'(bus_data), 'h3333);
        cycle();
        set_unit(3, 1'b0, 0, 0); #1;
        chk("R7 waiting unit granted", int'(done_grant), 'b0100);
        cycle();
        set_unit(2, 1'b0, 0, 0);
        check_all("R2");

        // R8: idle bus
        #1;
        chk("R8 bus_valid", int'(bus_valid), 0);
        chk("R8 grant", int'(done_grant), 0);
        chk("R8 rf_we", int'(rf_we), 0);
        @(negedge clk);

        // R9: rename and matching clear of the same register in one cycle
        iss_valid = 1'b1; iss_reg = 3'd2; iss_tag = 2'd1; cycle();
        iss_tag = 2'd3;
        set_unit(1, 1'b1, 7, 'h5A5A); #1;
        chk("R9 rf_we", int'(rf_we), 1);
        chk("R9 rf_waddr", int'(rf_waddr), 2);
        chk("R9 rf_wdata", int'(rf_wdata), 'h5A5A);
        cycle();
        iss_valid = 1'b0;
        set_unit(1, 1'b0, 0, 0);
        lka_reg = 3'd2; #1;
        chk("R9 pending", int'(lka_ready), 0);
        chk("R9 new tag", int'(lka_tag), 3);
        @(negedge clk);
        set_unit(3, 1'b1, 9, 'h7777);
        cycle();
        set_unit(3, 1'b0, 0, 0);
        lka_reg = 3'd2; #1;
        chk("R5 committed", int'(lka_value), 'h7777);
        @(negedge clk);
        check_all("R2");

        // R7 sweep: every unit pair, every sequence pair (all entries empty)
        for (int i = 0; i < NU; i++) begin
            for (int j = i + 1; j < NU; j++) begin
                for (int si = 0; si < 16; si++) begin
                    for (int sj = 0; sj < 16; sj++) begin
                        int w;
                        done_req = '0;
                        set_unit(i, 1'b1, si, 'hC000 + i);
                        set_unit(j, 1'b1, sj, 'hC000 + j);
                        w = ((((sj - si) & 8) != 0) ? j : i);
                        #1;
                        chk("R7 sweep grant", int'(done_grant), 1 << w);
                        chk("R7 sweep tag", int'(bus_tag), w);
                        chk("R7 sweep data", int'(bus_data), 'hC000 + w);
                    end
                end
            end
        end
        done_req = '0;

        // R7: three requesters across the wrap point
        set_unit(0, 1'b1, 15, 'h0F0F);
        set_unit(1, 1'b1, 1, 'h0101);
        set_unit(3, 1'b1, 14, 'h0E0E); #1;
        chk("R7 three-way grant", int'(done_grant), 'b1000);
        chk("R7 three-way data", int'(bus_data), 'h0E0E);
        chk("R6 no match no write", int'(rf_we), 0);
        done_req = '0;
        @(negedge clk);
        check_all("R6");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule